// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block decides, for each address byte seen after a START or repeated START, whether an I2C slave must acknowledge it. A bus-condition detector ahead of it supplies single-cycle START and STOP strobes. A byte shifter supplies each received byte with a one-cycle valid strobe. One cycle after an address byte arrives, the recognizer issues a decision pulse that the bit-level logic uses to drive or release SDA on the ninth clock.

Both address forms are handled:

- **7-bit addressing:** the top seven bits of the first byte are compared with the own address, and the byte's least significant bit is kept as the read/write direction.
- **10-bit addressing:** a first byte that begins with the header `11110` carries the two high address bits. A matching header is acknowledged, and the following byte is then compared with the eight low address bits.
- **General call:** when enabled, an all-zero first byte is acknowledged and flagged.
- **Don't-care mask:** a ten-bit mask makes chosen address bits don't-care in every comparison.

A sticky selected flag records a successful match. Every START or STOP clears it.

The control is a four-state machine:

| State | Meaning |
|---|---|
| `AR_IDLE` | No transfer open; bytes are ignored. |
| `AR_FIRST` | Waiting for the first address byte. |
| `AR_SECOND` | A 10-bit header matched; waiting for the low address byte. |
| `AR_DONE` | Address phase over; bytes are ignored until the next START. |

Its transitions are:

| From | Event | To |
|---|---|---|
| any state | START | `AR_FIRST` |
| any state | STOP without START | `AR_IDLE` |
| `AR_FIRST` | byte that is a matching 10-bit header | `AR_SECOND` |
| `AR_FIRST` | any other byte | `AR_DONE` |
| `AR_SECOND` | any byte | `AR_DONE` |

Top module: `i2c_addr_recog`

## Requirements
- R1: A byte strobed while in `AR_FIRST` or `AR_SECOND` produces exactly one `ack_vld_o` pulse on the following cycle. In that cycle, `ack_o` = 1 means acknowledge and 0 means not-acknowledge. `ack_vld_o` is never high unless `byte_vld_i` was high the cycle before.
- R2: In the first byte, bits [7:1] are compared with `own_addr_i[6:0]`. On a match the block acknowledges, sets `selected_o`, and copies bit [0] to `rw_o` (1 = read).
- R3: With `gc_en_i` = 1, a first byte of 8'h00 is acknowledged and sets `selected_o` and `gen_call_o`. With `gc_en_i` = 0, 8'h00 is refused unless it matches as a 7-bit address.
- R4: With `ten_bit_en_i` = 1, a first byte whose bits [7:3] are `11110` is a 10-bit header. Its bits [2:1] are compared with `own_addr_i[9:8]`. On a match the block acknowledges, sets `selected_o` and enters `AR_SECOND`. On a mismatch it refuses.
- R5: In `AR_SECOND`, the whole byte is compared with `own_addr_i[7:0]`. A match acknowledges and keeps `selected_o`. A mismatch refuses and clears `selected_o`.
- R6: With `ten_bit_en_i` = 1, a header byte is never given the 7-bit compare. With `ten_bit_en_i` = 0, the same byte is compared as an ordinary 7-bit address. Other first bytes use the 7-bit compare in either mode.
- R7: An `addr_mask_i` bit of 1 makes the matching own-address bit don't-care in every compare. A mask bit of 0 requires equality.
- R8: A START or STOP strobe clears `selected_o`, `gen_call_o` and `rw_o` on the next cycle. A byte strobed in the same cycle as START or STOP is dropped and gives no decision.
- R9: Bytes strobed in `AR_IDLE` or `AR_DONE` give no decision and leave `selected_o` unchanged.
- R10: After reset, `ack_vld_o`, `ack_o`, `selected_o`, `rw_o` and `gen_call_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START or repeated START strobe |
| stop_i | input | 1 | STOP strobe |
| byte_vld_i | input | 1 | Received byte valid strobe |
| byte_i | input | 8 | Received byte |
| own_addr_i | input | 10 | Own slave address |
| addr_mask_i | input | 10 | Don't-care mask (1 = ignore bit) |
| gc_en_i | input | 1 | General call enable |
| ten_bit_en_i | input | 1 | 10-bit addressing enable |
| ack_vld_o | output | 1 | Decision pulse for the current address byte |
| ack_o | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| selected_o | output | 1 | Slave addressed since the last START |
| rw_o | output | 1 | Captured direction bit (1 = read) |
| gen_call_o | output | 1 | Selected by general call |

## Verification
The bench probes a byte whose top bits look like a 10-bit header but also equal the 7-bit address. A recognizer that applied both compares would acknowledge it in 10-bit mode; a correct one refuses it. It also sends a matching header followed by a wrong low byte. A design that kept the flag set after the header would leave the slave selected for a transfer addressed elsewhere. Bytes are sent after the address phase, after a STOP and in the same cycle as a START. A design that kept deciding would produce stray acknowledges on data bytes. Finally, the bench uses mask patterns that differ only in don't-care bits, and patterns that differ in one bit the mask does not cover, to catch an inverted or misaligned mask.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;

    typedef enum logic [1:0] {
        AR_IDLE,
        AR_FIRST,
        AR_SECOND,
        AR_DONE
    } ar_state_e;

    typedef struct packed {
        logic hdr10;
        logic hdr_hit;
        logic own7_hit;
        logic gcall_hit;
        logic low_hit;
    } ar_hits_t;

endpackage

// File: rtl/ar_mask_cmp.sv
module ar_mask_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx_i,
    input  logic [W-1:0] ref_i,
    input  logic [W-1:0] dc_i,
    output logic         hit_o
);

    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = dc_i[i] | (rx_i[i] ~^ ref_i[i]);
    end

    assign hit_o = &bit_ok;

endmodule

// File: rtl/ar_decode.sv
module ar_decode
    import i2c_ar_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] addr_mask_i,
    input  logic              gc_en_i,
    input  logic              ten_bit_en_i,
    output ar_hits_t          hits_o
);

    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int SEV_W = BYTE_W - 1;
    localparam int HDR_W = SEV_W - HI_W;
    localparam logic [HDR_W-1:0] HDR_PAT = {{(HDR_W-1){1'b1}}, 1'b0};

    logic hi_hit, sev_hit, lo_hit;

    ar_mask_cmp #(.W(HI_W)) u_cmp_hi (
        .rx_i  (rx_byte_i[HI_W:1]),
        .ref_i (own_addr_i[ADDR_W-1 -: HI_W]),
        .dc_i  (addr_mask_i[ADDR_W-1 -: HI_W]),
        .hit_o (hi_hit)
    );

    ar_mask_cmp #(.W(SEV_W)) u_cmp_sev (
        .rx_i  (rx_byte_i[BYTE_W-1:1]),
        .ref_i (own_addr_i[SEV_W-1:0]),
        .dc_i  (addr_mask_i[SEV_W-1:0]),
        .hit_o (sev_hit)
    );

    ar_mask_cmp #(.W(BYTE_W)) u_cmp_lo (
        .rx_i  (rx_byte_i),
        .ref_i (own_addr_i[BYTE_W-1:0]),
        .dc_i  (addr_mask_i[BYTE_W-1:0]),
        .hit_o (lo_hit)
    );

    always_comb begin
        hits_o.hdr10     = ten_bit_en_i && (rx_byte_i[BYTE_W-1 -: HDR_W] == HDR_PAT);
        hits_o.hdr_hit   = hi_hit;
        hits_o.own7_hit  = sev_hit;
        hits_o.gcall_hit = gc_en_i && (rx_byte_i == '0);
        hits_o.low_hit   = lo_hit;
    end

endmodule

// File: rtl/ar_fsm.sv
module ar_fsm
    import i2c_ar_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     stop_i,
    input  logic     byte_vld_i,
    input  logic     rx_lsb_i,
    input  ar_hits_t hits_i,
    output logic     ack_vld_o,
    output logic     ack_o,
    output logic     selected_o,
    output logic     rw_o,
    output logic     gen_call_o
);

    ar_state_e state_q, state_d;
    logic vld_d, ack_d, sel_d, rw_d, gc_d;

    always_comb begin
        state_d = state_q;
        vld_d   = 1'b0;
        ack_d   = 1'b0;
        sel_d   = selected_o;
        rw_d    = rw_o;
        gc_d    = gen_call_o;
        if (start_i || stop_i) begin
            state_d = start_i ? AR_FIRST : AR_IDLE;
            sel_d   = 1'b0;
            rw_d    = 1'b0;
            gc_d    = 1'b0;
        end else if (byte_vld_i) begin
            unique case (state_q)
                AR_FIRST: begin
                    vld_d = 1'b1;
                    if (hits_i.hdr10) begin
                        ack_d   = hits_i.hdr_hit;
                        sel_d   = hits_i.hdr_hit;
                        state_d = hits_i.hdr_hit ? AR_SECOND : AR_DONE;
                    end else if (hits_i.own7_hit || hits_i.gcall_hit) begin
                        ack_d   = 1'b1;
                        sel_d   = 1'b1;
                        rw_d    = rx_lsb_i;
                        gc_d    = hits_i.gcall_hit;
                        state_d = AR_DONE;
                    end else begin
                        state_d = AR_DONE;
                    end
                end
                AR_SECOND: begin
                    vld_d   = 1'b1;
                    ack_d   = hits_i.low_hit;
                    sel_d   = hits_i.low_hit;
                    state_d = AR_DONE;
                end
                AR_IDLE, AR_DONE: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld_o  <= 1'b0;
            ack_o      <= 1'b0;
            selected_o <= 1'b0;
            rw_o       <= 1'b0;
            gen_call_o <= 1'b0;
        end else begin
            ack_vld_o  <= vld_d;
            ack_o      <= ack_d;
            selected_o <= sel_d;
            rw_o       <= rw_d;
            gen_call_o <= gc_d;
        end
    end

endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
    import i2c_ar_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] addr_mask_i,
    input  logic              gc_en_i,
    input  logic              ten_bit_en_i,
    output logic              ack_vld_o,
    output logic              ack_o,
    output logic              selected_o,
    output logic              rw_o,
    output logic              gen_call_o
);

    ar_hits_t hits;

    ar_decode #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_decode (
        .rx_byte_i    (byte_i),
        .own_addr_i   (own_addr_i),
        .addr_mask_i  (addr_mask_i),
        .gc_en_i      (gc_en_i),
        .ten_bit_en_i (ten_bit_en_i),
        .hits_o       (hits)
    );

    ar_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .byte_vld_i (byte_vld_i),
        .rx_lsb_i   (byte_i[0]),
        .hits_i     (hits),
        .ack_vld_o  (ack_vld_o),
        .ack_o      (ack_o),
        .selected_o (selected_o),
        .rw_o       (rw_o),
        .gen_call_o (gen_call_o)
    );

endmodule

// File: rtl/ar_checks.sv
module ar_checks (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic stop_i,
    input logic byte_vld_i,
    input logic ack_vld_o,
    input logic ack_o,
    input logic selected_o,
    input logic gen_call_o
);

    p_vld_follows_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> $past(byte_vld_i));

    p_ack_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld_o && ack_o) |-> selected_o);

    p_gcall_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gen_call_o |-> selected_o);

    p_nack_deselects_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld_o && !ack_o) |-> !selected_o);

    p_cond_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || stop_i) |=> (!selected_o && !gen_call_o && !ack_vld_o));

    p_sel_rise_on_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected_o) |-> (ack_vld_o && ack_o));

endmodule

bind i2c_addr_recog ar_checks u_ar_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .ack_vld_o  (ack_vld_o),
    .ack_o      (ack_o),
    .selected_o (selected_o),
    .gen_call_o (gen_call_o)
);

// File: tb/tb_i2c_addr_recog.sv
`timescale 1ns/1ps
module tb_i2c_addr_recog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic [9:0] own_addr_i = '0, addr_mask_i = '0;
    logic       gc_en_i = 1'b0, ten_bit_en_i = 1'b0;
    logic       ack_vld_o, ack_o, selected_o, rw_o, gen_call_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_addr_recog dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .own_addr_i(own_addr_i),
        .addr_mask_i(addr_mask_i), .gc_en_i(gc_en_i), .ten_bit_en_i(ten_bit_en_i),
        .ack_vld_o(ack_vld_o), .ack_o(ack_o), .selected_o(selected_o),
        .rw_o(rw_o), .gen_call_o(gen_call_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); byte_i = b; byte_vld_i = 1'b1;
        @(negedge clk); byte_vld_i = 1'b0;
    endtask

    // decision = {ack_vld, ack, selected}
    task automatic expect_dec(input string tag, input logic v, input logic a, input logic s);
        check(tag, {29'd0, ack_vld_o, ack_o, selected_o}, {29'd0, v, a, s});
    endtask

    task automatic t_reset();
        check("R10 reset outputs", {27'd0, ack_vld_o, ack_o, selected_o, rw_o, gen_call_o}, 32'd0);
    endtask

    task automatic t_seven_bit();
        own_addr_i = 10'h05A; addr_mask_i = '0; gc_en_i = 0; ten_bit_en_i = 0;
        do_start();
        send_byte(8'hB5);
        expect_dec("R2 R1 7-bit read match", 1, 1, 1);
        check("R2 rw read", rw_o, 1);
        send_byte(8'h12);
        expect_dec("R9 byte after address phase", 0, 0, 1);
        do_stop();
        check("R8 stop clears select/rw", {30'd0, selected_o, rw_o}, 0);
        do_start();
        send_byte(8'hB4);
        expect_dec("R2 7-bit write match", 1, 1, 1);
        check("R2 rw write", rw_o, 0);
        do_start();
        send_byte(8'hC4);
        expect_dec("R2 7-bit mismatch nack", 1, 0, 0);
    endtask

    task automatic t_gcall();
        own_addr_i = 10'h05A; addr_mask_i = '0; gc_en_i = 1; ten_bit_en_i = 0;
        do_start();
        send_byte(8'h00);
        expect_dec("R3 general call ack", 1, 1, 1);
        check("R3 gen_call flag", {30'd0, gen_call_o, rw_o}, 32'h2);
        do_start();
        check("R8 restart clears gen_call", {30'd0, gen_call_o, selected_o}, 0);
        gc_en_i = 0;
        send_byte(8'h00);
        expect_dec("R3 general call disabled nack", 1, 0, 0);
        check("R3 no gen_call when disabled", gen_call_o, 0);
    endtask

    task automatic t_mask();
        own_addr_i = 10'h05A; addr_mask_i = 10'h003; gc_en_i = 0; ten_bit_en_i = 0;
        do_start();
        send_byte(8'hB2);
        expect_dec("R7 masked bits ignored", 1, 1, 1);
        do_start();
        send_byte(8'hBC);
        expect_dec("R7 unmasked bit differs", 1, 0, 0);
        own_addr_i = 10'h2A5; addr_mask_i = 10'h300; ten_bit_en_i = 1;
        do_start();
        send_byte(8'hF2);
        expect_dec("R7 masked 10-bit header bits", 1, 1, 1);
    endtask

    task automatic t_ten_bit();
        own_addr_i = 10'h2A5; addr_mask_i = '0; gc_en_i = 0; ten_bit_en_i = 1;
        do_start();
        send_byte(8'hF4);
        expect_dec("R4 header match", 1, 1, 1);
        send_byte(8'hA5);
        expect_dec("R5 low byte match", 1, 1, 1);
        send_byte(8'hA5);
        expect_dec("R9 no decision after 10-bit phase", 0, 0, 1);
        do_start();
        send_byte(8'hF2);
        expect_dec("R4 header mismatch", 1, 0, 0);
        send_byte(8'hA5);
        expect_dec("R9 no decision after failed header", 0, 0, 0);
        do_start();
        send_byte(8'hF4);
        expect_dec("R4 header match again", 1, 1, 1);
        send_byte(8'hA4);
        expect_dec("R5 low byte mismatch clears", 1, 0, 0);
        do_start();
        send_byte(8'h4A);
        expect_dec("R6 7-bit compare still used for non-header", 1, 1, 1);
    endtask

    task automatic t_no_double();
        own_addr_i = 10'h07A; addr_mask_i = '0; gc_en_i = 0; ten_bit_en_i = 1;
        do_start();
        send_byte(8'hF4);
        expect_dec("R6 header not 7-bit compared", 1, 0, 0);
        ten_bit_en_i = 0;
        do_start();
        send_byte(8'hF4);
        expect_dec("R6 header byte as 7-bit address", 1, 1, 1);
    endtask

    task automatic t_priority();
        own_addr_i = 10'h05A; addr_mask_i = '0; gc_en_i = 0; ten_bit_en_i = 0;
        do_stop();
        send_byte(8'hB5);
        expect_dec("R9 byte while idle ignored", 0, 0, 0);
        do_start();
        @(negedge clk); start_i = 1; byte_vld_i = 1; byte_i = 8'hB5;
        @(negedge clk); start_i = 0; byte_vld_i = 0;
        expect_dec("R8 byte with START dropped", 0, 0, 0);
        send_byte(8'hB5);
        expect_dec("R8 next byte decided after START", 1, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seven_bit();
        t_gcall();
        t_mask();
        t_ten_bit();
        t_no_double();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule